// File: doc/BRIEF.md
# Dual Prescaled Clock-Enable Generator

This block turns one peripheral clock into two independent streams of single-cycle enable pulses, named A and B, that PWM channels use to advance their counters. Nothing here gates or divides the real clock; every output is a one-cycle-wide qualifier in the peripheral clock domain.

Each stream is a cascade of two stages. The first stage takes one power-of-two tap from a free-running prescaler that both streams share. The second stage is an 8-bit linear divider that counts the selected taps and emits one enable per N of them. A divide factor of zero switches the stream off. One 32-bit mode word, loaded through a write strobe, configures both streams. A write that changes a stream's settings restarts that stream cleanly. A write that leaves a stream's settings as they were does not touch that stream.

Top module: `pwmcg_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both enables are low, the stored mode word is all zeros, and neither enable pulses until a nonzero divide factor is written.
- R2: The mode word fields are: A divide factor in bits 7:0, A tap code in bits 11:8, B divide factor in bits 23:16, B tap code in bits 27:24. Bits 15:12 and 31:28 are ignored.
- R3: The shared prescaler count is 0 in the first cycle after reset is released and increments by one each cycle, wrapping after 1023. Tap code k (0..10) is active in a cycle whose count has its low k bits all zero, so code 0 is active in every cycle. An enable goes high in the cycle after the tap that completes its count.
- R4: Tap codes 11 through 15 select no tap, so that stream produces no enables.
- R5: A divide factor of 0 produces no enables on that stream, whatever the tap code.
- R6: A divide factor of 1 gives one enable for every active cycle of the selected tap.
- R7: A divide factor N from 2 to 255 gives one enable for every N active cycles of the selected tap, which is a period of N times 2^k cycles.
- R8: When the period is longer than one cycle, each enable is high for exactly one cycle.
- R9: A write that changes a stream's divide factor or tap code holds that stream's enable low in the cycle after the write and clears its count. A tap in the write cycle is not counted, so the first new enable follows the Nth selected tap after the write.
- R10: A write that leaves a stream's divide factor and tap code unchanged does not alter that stream's enable sequence.
- R11: The two streams run independently, and both take their taps from the single shared prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_word | input | 32 | Configuration word for both streams |
| mode_we | input | 1 | Loads mode_word at the clock edge |
| en_a | output | 1 | Stream A enable pulse |
| en_b | output | 1 | Stream B enable pulse |

## Verification
A configuration write can land in the same cycle as a selected tap that would complete a stream's count. The design must then drop that pulse and restart the count, not emit a final pulse under the old ratio. The bench provokes this on purpose: it runs tap code 0 with a small divide factor and issues writes at each of the possible count phases. Random write timing adds more cases. For each cycle, a bench model built from the requirements predicts both enables, and the bench confirms that the stream changed by the write is silent in the following cycle while the unchanged stream keeps its cadence.

// File: rtl/pwmcg_pkg.sv
// Shared sizes, the per-stream configuration type and the mode-word
// field extraction used by the dual clock-enable generator.
package pwmcg_pkg;

    localparam int PRE_W         = 10;  // prescaler width, taps 0..PRE_W
    localparam int DIV_W         = 8;   // linear divide factor width
    localparam int SEL_W         = 4;   // tap code width
    localparam int NUM_STREAMS   = 2;   // stream A = 0, stream B = 1
    localparam int STREAM_STRIDE = 16;  // bit distance between stream fields
    localparam int SEL_OFS       = 8;   // tap code offset inside a stream field
    localparam int MODE_W        = 32;  // mode word width

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } stream_cfg_t;

    // Pull one stream's settings out of the mode word.
    function automatic stream_cfg_t extract_cfg(input logic [MODE_W-1:0] word,
                                                input int                 idx);
        stream_cfg_t c;
        c.div = word[idx*STREAM_STRIDE +: DIV_W];
        c.sel = word[idx*STREAM_STRIDE + SEL_OFS +: SEL_W];
        return c;
    endfunction

endpackage

// File: rtl/pwmcg_prescaler.sv
// Free-running shared prescaler.
// Provides one tap strobe per power of two, 2^0 .. 2^PRE_W.
// Tap k is high in every cycle where the low k count bits are zero.
// Tap 0 is high in every cycle.
// Assumes a synchronous active-low reset that returns the count to zero.
module pwmcg_prescaler #(
    parameter int PRE_W = pwmcg_pkg::PRE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [PRE_W:0] taps_o
);

    logic [PRE_W-1:0] cnt_q;

    // Advance the shared count every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign taps_o[0] = 1'b1;

    // One zero-detect on the low bits per tap.
    for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
        assign taps_o[k] = (cnt_q[k-1:0] == '0);
    end

    // R3
    prescale_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_q == $past(cnt_q) + 1'b1);

    // R3
    widest_tap_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taps_o[PRE_W] |=> !taps_o[PRE_W]);

endmodule

// File: rtl/pwmcg_tap_sel.sv
// Tap selector: forwards the prescaler tap named by the tap code.
// Codes above PRE_W are reserved and select nothing.
// This module is purely combinational.
module pwmcg_tap_sel #(
    parameter int PRE_W = pwmcg_pkg::PRE_W,
    parameter int SEL_W = pwmcg_pkg::SEL_W
) (
    input  logic [PRE_W:0]   taps_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tap_o
);

    // Decode the tap code. A reserved code leaves the output low.
    always_comb begin
        tap_o = 1'b0;
        for (int k = 0; k <= PRE_W; k++) begin
            if (sel_i == SEL_W'(k)) tap_o = taps_i[k];
        end
    end

endmodule

// File: rtl/pwmcg_lin_div.sv
// Linear divider: counts selected taps and emits a one-cycle enable
// on every div_i-th tap. div_i == 0 keeps the output silent.
// clr_i restarts the count, drops any pulse due, and ignores the tap
// in that cycle. Assumes div_i only changes when clr_i is high.
module pwmcg_lin_div #(
    parameter int DIV_W = pwmcg_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             clr_i,
    output logic             en_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             en_q;
    logic             last_tap;

    assign last_tap = (cnt_q == DIV_W'(div_i - 1'b1));

    // Count taps, wrap at the divide factor, register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (tap_i && (div_i != '0)) begin
            if (last_tap) begin
                cnt_q <= '0;
                en_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                en_q  <= 1'b0;
            end
        end else begin
            en_q <= 1'b0;
        end
    end

    assign en_o = en_q;

    // R5
    off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0) |=> !en_o);

    // R9
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !en_o && cnt_q == '0);

    // R8
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && div_i > DIV_W'(1)) |=> !en_o);

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i != '0) |-> cnt_q < div_i);

    // R6
    no_tap_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tap_i |=> !en_o);

endmodule

// File: rtl/pwmcg_top.sv
// Dual prescaled clock-enable generator.
// Holds the mode word, runs one shared prescaler, and builds each stream
// from a tap selector followed by a linear divider.
// A write clears a stream's count only if that stream's fields change.
// Reset is synchronous and active low.
module pwmcg_top (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] mode_word,
    input  logic        mode_we,
    output logic        en_a,
    output logic        en_b
);
    import pwmcg_pkg::*;

    stream_cfg_t          cfg_q   [NUM_STREAMS];
    stream_cfg_t          cfg_new [NUM_STREAMS];
    logic [NUM_STREAMS-1:0] clr;
    logic [NUM_STREAMS-1:0] tap_sel;
    logic [NUM_STREAMS-1:0] en;
    logic [PRE_W:0]         taps;

    pwmcg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .taps_o (taps)
    );

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        assign cfg_new[s] = extract_cfg(mode_word, s);
        assign clr[s]     = mode_we && (cfg_new[s] != cfg_q[s]);

        // Hold this stream's settings, load them on a write.
        always_ff @(posedge clk) begin
            if (!rst_n)       cfg_q[s] <= '0;
            else if (mode_we) cfg_q[s] <= cfg_new[s];
        end

        pwmcg_tap_sel #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_sel (
            .taps_i (taps),
            .sel_i  (cfg_q[s].sel),
            .tap_o  (tap_sel[s])
        );

        pwmcg_lin_div #(.DIV_W(DIV_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .tap_i (tap_sel[s]),
            .div_i (cfg_q[s].div),
            .clr_i (clr[s]),
            .en_o  (en[s])
        );
    end

    assign en_a = en[0];
    assign en_b = en[1];

    // R2
    field_b_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> cfg_q[1].div == $past(mode_word[23:16]));

    // R2
    field_a_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> cfg_q[0].sel == $past(mode_word[11:8]));

    // R4
    reserved_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[0].sel > SEL_W'(PRE_W)) |=> !en_a);

    // R4
    reserved_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[1].sel > SEL_W'(PRE_W)) |=> !en_b);

    // R10
    keep_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && cfg_new[1] == cfg_q[1]) |=> $stable(cfg_q[1]));

endmodule

// File: tb/pwmcg_top_tb_top.sv
`timescale 1ns/1ps
module pwmcg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mode_word = '0;
    logic        mode_we = 1'b0;
    logic        en_a, en_b;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // model state
    int m_pre;
    int m_div [2];
    int m_sel [2];
    int m_cnt [2];
    bit m_en  [2];
    int n_pre;
    int n_div [2];
    int n_sel [2];
    int n_cnt [2];
    bit n_en  [2];

    pwmcg_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_word (mode_word),
        .mode_we   (mode_we),
        .en_a      (en_a),
        .en_b      (en_b)
    );

    always #5 clk = ~clk;

    function automatic bit tap_fn(int pre, int sel);
        if (sel > 10) return 1'b0;
        if (sel == 0) return 1'b1;
        return (pre & ((1 << sel) - 1)) == 0;
    endfunction

    function automatic int fld_div(logic [31:0] w, int s);
        return (s == 0) ? int'(w[7:0]) : int'(w[23:16]);
    endfunction

    function automatic int fld_sel(logic [31:0] w, int s);
        return (s == 0) ? int'(w[11:8]) : int'(w[27:24]);
    endfunction

    function automatic logic [31:0] mk_word(int da, int sa, int db, int sb);
        logic [31:0] w;
        w = '0;
        w[7:0]   = 8'(da);
        w[11:8]  = 4'(sa);
        w[23:16] = 8'(db);
        w[27:24] = 4'(sb);
        return w;
    endfunction

    // Next model state from the present state and the driven inputs.
    task automatic model_next();
        if (!rst_n) begin
            n_pre = 0;
            for (int s = 0; s < 2; s++) begin
                n_div[s] = 0; n_sel[s] = 0; n_cnt[s] = 0; n_en[s] = 0;
            end
        end else begin
            n_pre = (m_pre + 1) % 1024;
            for (int s = 0; s < 2; s++) begin
                int  nd = fld_div(mode_word, s);
                int  ns = fld_sel(mode_word, s);
                bit  chg = mode_we && (nd != m_div[s] || ns != m_sel[s]);
                n_cnt[s] = m_cnt[s];
                n_en[s]  = 0;
                if (chg) begin
                    n_cnt[s] = 0;
                end else if (tap_fn(m_pre, m_sel[s]) && m_div[s] != 0) begin
                    if (m_cnt[s] == m_div[s] - 1) begin
                        n_cnt[s] = 0; n_en[s] = 1;
                    end else begin
                        n_cnt[s] = m_cnt[s] + 1;
                    end
                end
                n_div[s] = mode_we ? nd : m_div[s];
                n_sel[s] = mode_we ? ns : m_sel[s];
            end
        end
    endtask

    task automatic check_bit(string what, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // One clock: predict, step, then compare at the falling edge.
    task automatic tick();
        model_next();
        @(posedge clk);
        @(negedge clk);
        m_pre = n_pre;
        for (int s = 0; s < 2; s++) begin
            m_div[s] = n_div[s]; m_sel[s] = n_sel[s];
            m_cnt[s] = n_cnt[s]; m_en[s]  = n_en[s];
        end
        check_bit("en_a", en_a, m_en[0]);
        check_bit("en_b", en_b, m_en[1]);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_mode(logic [31:0] w);
        mode_word = w;
        mode_we   = 1'b1;
        tick();
        mode_we   = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt_pulses;
        void'($urandom(32'd20240611));
        m_pre = 0;
        for (int s = 0; s < 2; s++) begin
            m_div[s] = 0; m_sel[s] = 0; m_cnt[s] = 0; m_en[s] = 0;
        end
        @(negedge clk);

        // R1: reset state, then silence with the reset mode word
        cur_req = "R1";
        run(3);
        rst_n = 1'b1;
        run(40);

        // R6 and R3: pass-through on tap 0 and on tap 3
        cur_req = "R6";
        write_mode(mk_word(1, 0, 1, 3));
        run(40);
        cur_req = "R3";
        write_mode(mk_word(1, 10, 1, 3));
        run(2100);

        // R2: junk in unused bits is ignored
        cur_req = "R2";
        write_mode(mk_word(2, 1, 3, 2) | 32'hF000_F000);
        run(60);

        // R7 and R8: divided streams
        cur_req = "R7";
        write_mode(mk_word(5, 2, 255, 0));
        run(1200);
        cur_req = "R8";
        cnt_pulses = 0;
        for (int i = 0; i < 255; i++) begin
            tick();
            if (en_b) cnt_pulses++;
        end
        checks++;
        if (cnt_pulses != 1) begin
            errors++;
            $display("FAIL R8 en_b pulses in 255 cycles actual=%0d expected=1", cnt_pulses);
        end

        // R5: divide factor zero on every tap code
        cur_req = "R5";
        for (int k = 0; k < 16; k++) begin
            write_mode(mk_word(0, k, 1, 0));
            run(20);
        end

        // R4: reserved tap codes
        cur_req = "R4";
        for (int k = 11; k < 16; k++) begin
            write_mode(mk_word(1, k, 1, k));
            run(30);
        end

        // R9: writes landing at each count phase, tap in same cycle
        cur_req = "R9";
        for (int o = 0; o < 3; o++) begin
            write_mode(mk_word(3, 0, 7, 0));
            run(10 + o);
            write_mode(mk_word(4, 0, 7, 0));
            run(20);
        end

        // R10: repeated identical writes must not disturb either stream
        cur_req = "R10";
        write_mode(mk_word(3, 1, 7, 0));
        for (int i = 0; i < 40; i++) begin
            write_mode(mk_word(3, 1, 7, 0));
            run(i % 5);
        end

        // R11: random configurations and write timing
        cur_req = "R11";
        for (int it = 0; it < 90; it++) begin
            int da = ($urandom % 4 == 0) ? int'($urandom % 4) : int'($urandom % 256);
            int db = ($urandom % 4 == 0) ? int'($urandom % 4) : int'($urandom % 256);
            int sa = ($urandom % 8 == 0) ? int'($urandom % 16) : int'($urandom % 6);
            int sb = ($urandom % 8 == 0) ? int'($urandom % 16) : int'($urandom % 6);
            if ($urandom % 3 == 0) begin
                sb = m_sel[1]; db = m_div[1];
            end
            write_mode(mk_word(da, sa, db, sb) | ($urandom & 32'hF000_F000));
            run(50 + int'($urandom % 900));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule